// File: doc/BRIEF.md
# Three-Way Junction Green Arbiter

This block drives the green outputs of a T-shaped road junction with three approaches: two trunk approaches facing each other (north and south) and one side approach (east). Every approach has a vehicle-present input and a green output. Trunk traffic from both directions may flow together, but side traffic must never flow while either trunk green is on. All state is registered on one clock with a synchronous active-high reset.

A vehicle seen on an approach is remembered as a pending request until that approach has had its green. Two lock flags arbitrate. The trunk lock is shared by both trunk controllers and is set on the same edge as a trunk green. The side lock is taken by the side controller before it waits for the trunk lock to clear. A green stays on while its vehicle input stays high and drops on the edge after that input falls. The trunk lock hand-off rules are written so that a trunk green ending together with, or just after, the opposite trunk green never leaves the lock stuck. They also stop a trunk green from starting in the cycle where the opposite trunk green is ending.

Top module: `tjx_junction_arbiter`

## Requirements
- R1: While reset is high, all three green outputs are 0, whatever the vehicle inputs do.
- R2: A vehicle input high for a single clock edge records a request that is served later, even if the input is already low again.
- R3: With no conflicting traffic, a green output goes to 1 on the third rising edge after its vehicle input is first sampled high.
- R4: A green output stays 1 while its vehicle input is high and goes to 0 on the first edge that samples the input low. The request is then cleared, so no second green follows without a new vehicle.
- R5: The east green is never 1 in a cycle where the north or south green is 1.
- R6: North and south greens may be on together. When both request with no side traffic, both turn on in the same cycle.
- R7: Once the east controller holds its lock, no trunk green starts. East turns green on the second edge after the last trunk green goes off. A trunk request waiting behind east turns green on the second edge after east goes off.
- R8: A trunk green does not start on an edge where the opposite trunk green is on with its vehicle input low. It starts on the next edge instead, and the trunk lock still covers it.
- R9: When north and south greens end on the same edge, the trunk lock is freed. A later east request is then served with the R3 latency.
- R10: When one trunk green ends while the other continues, the trunk lock stays held. East turns green on the second edge after the remaining trunk green goes off.
- R11: Under random vehicle traffic in which every input falls again within a few cycles, every pending request is served within 80 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| north_car_i | input | 1 | Vehicle present on the north approach |
| south_car_i | input | 1 | Vehicle present on the south approach |
| east_car_i | input | 1 | Vehicle present on the east approach |
| north_green_o | output | 1 | North green light |
| south_green_o | output | 1 | South green light |
| east_green_o | output | 1 | East green light |

## Verification
Single-approach arrivals, including a one-edge pulse, show whether the request latch works and whether the three-edge start and the hold-until-clear rule are timed correctly. Paired trunk arrivals tell correct overlap apart from false serialisation. Trunk greens that end simultaneously or staggered, and a trunk arrival timed to meet the opposite green's last cycle, reveal a lock that is stuck, released early, or handed over at the wrong moment. East arriving behind running trunk traffic, and random traffic on all three inputs, separate correct exclusion and fair service from collisions and starvation.

// File: rtl/tjx_pkg.sv
package tjx_pkg;

    // Index of each approach inside the request vector.
    localparam int IDX_NORTH = 0;
    localparam int IDX_SOUTH = 1;
    localparam int IDX_EAST  = 2;
    localparam int NUM_APPR  = 3;
    localparam int NUM_TRUNK = 2;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_WAIT = 2'd1,
        TRK_GO   = 2'd2
    } trk_state_e;

    typedef enum logic [1:0] {
        SIDE_IDLE = 2'd0,
        SIDE_HOLD = 2'd1,
        SIDE_GO   = 2'd2
    } side_state_e;

    typedef struct packed {
        trk_state_e st;
        logic       green;
    } trk_regs_t;

    typedef struct packed {
        side_state_e st;
        logic        lock;
        logic        green;
    } side_regs_t;

    typedef struct packed {
        logic trunk_lock;
    } top_regs_t;

endpackage

// File: rtl/tjx_req_latch.sv
module tjx_req_latch #(
    parameter int WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] car_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] req_o
);

    logic [WIDTH-1:0] req_d;
    logic [WIDTH-1:0] req_q;

    // A request is kept until its approach reports service; a clear wins.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            req_d[i] = (req_q[i] | car_i[i]) & ~clr_i[i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_o = req_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_chk
        AST_REQ_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
            (car_i[g] && !clr_i[g]) |=> req_o[g]);                       // R2
        AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
            (clr_i[g] && !car_i[g]) |=> !req_o[g]);                      // R4
    end

endmodule

// File: rtl/tjx_trunk_ctrl.sv
module tjx_trunk_ctrl
    import tjx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    input  logic car_i,
    input  logic side_lock_i,
    input  logic peer_green_i,
    input  logic peer_car_i,
    output logic green_o,
    output logic lock_set_o,
    output logic lock_rel_o,
    output logic served_o
);

    trk_regs_t cur_q;
    trk_regs_t nxt_d;
    logic      peer_ending;
    logic      may_start;

    assign peer_ending = peer_green_i & ~peer_car_i;
    assign may_start   = ~side_lock_i & ~peer_ending;

    always_comb begin
        nxt_d      = cur_q;
        lock_set_o = 1'b0;
        lock_rel_o = 1'b0;
        served_o   = 1'b0;
        case (cur_q.st)
            TRK_IDLE: begin
                if (req_i) begin
                    nxt_d.st = TRK_WAIT;
                end
            end
            TRK_WAIT: begin
                // Check and claim of the trunk lock happen on one edge.
                if (may_start) begin
                    nxt_d.st    = TRK_GO;
                    nxt_d.green = 1'b1;
                    lock_set_o  = 1'b1;
                end
            end
            TRK_GO: begin
                if (!car_i) begin
                    nxt_d.st    = TRK_IDLE;
                    nxt_d.green = 1'b0;
                    served_o    = 1'b1;
                    // Free the lock unless the opposite green carries on.
                    lock_rel_o  = ~peer_green_i | ~peer_car_i;
                end
            end
            default: begin
                nxt_d.st    = TRK_IDLE;
                nxt_d.green = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q.st    <= TRK_IDLE;
            cur_q.green <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign green_o = cur_q.green;

    AST_TRUNK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (green_o && car_i) |=> green_o);                                 // R4
    AST_TRUNK_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        (green_o && !car_i) |=> !green_o);                               // R4
    AST_TRUNK_BLOCKED_BY_SIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!green_o && side_lock_i) |=> !green_o);                         // R7
    AST_TRUNK_NO_START_ON_PEER_END: assert property (@(posedge clk_i) disable iff (rst_i)
        (!green_o && peer_green_i && !peer_car_i) |=> !green_o);         // R8

endmodule

// File: rtl/tjx_side_ctrl.sv
module tjx_side_ctrl
    import tjx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    input  logic car_i,
    input  logic trunk_lock_i,
    output logic green_o,
    output logic lock_o,
    output logic served_o
);

    side_regs_t cur_q;
    side_regs_t nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        served_o = 1'b0;
        case (cur_q.st)
            SIDE_IDLE: begin
                // Claim the side lock first, before looking at the trunk.
                if (req_i) begin
                    nxt_d.st   = SIDE_HOLD;
                    nxt_d.lock = 1'b1;
                end
            end
            SIDE_HOLD: begin
                if (!trunk_lock_i) begin
                    nxt_d.st    = SIDE_GO;
                    nxt_d.green = 1'b1;
                end
            end
            SIDE_GO: begin
                if (!car_i) begin
                    nxt_d.st    = SIDE_IDLE;
                    nxt_d.green = 1'b0;
                    nxt_d.lock  = 1'b0;
                    served_o    = 1'b1;
                end
            end
            default: begin
                nxt_d.st    = SIDE_IDLE;
                nxt_d.green = 1'b0;
                nxt_d.lock  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q.st    <= SIDE_IDLE;
            cur_q.lock  <= 1'b0;
            cur_q.green <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign green_o = cur_q.green;
    assign lock_o  = cur_q.lock;

    AST_SIDE_GREEN_UNDER_LOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        green_o |-> lock_o);                                             // R7
    AST_SIDE_START_NEEDS_FREE_TRUNK: assert property (@(posedge clk_i) disable iff (rst_i)
        (!green_o && trunk_lock_i) |=> !green_o);                        // R5
    AST_SIDE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (green_o && car_i) |=> green_o);                                 // R4

endmodule

// File: rtl/tjx_junction_arbiter.sv
module tjx_junction_arbiter
    import tjx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic north_car_i,
    input  logic south_car_i,
    input  logic east_car_i,
    output logic north_green_o,
    output logic south_green_o,
    output logic east_green_o
);

    logic [NUM_APPR-1:0]  car_vec;
    logic [NUM_APPR-1:0]  req_vec;
    logic [NUM_APPR-1:0]  served_vec;
    logic [NUM_APPR-1:0]  green_vec;
    logic [NUM_TRUNK-1:0] lock_set;
    logic [NUM_TRUNK-1:0] lock_rel;
    logic                 side_lock;
    top_regs_t            top_q;
    top_regs_t            top_d;

    assign car_vec[IDX_NORTH] = north_car_i;
    assign car_vec[IDX_SOUTH] = south_car_i;
    assign car_vec[IDX_EAST]  = east_car_i;

    tjx_req_latch #(
        .WIDTH (NUM_APPR)
    ) req_latch_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .car_i (car_vec),
        .clr_i (served_vec),
        .req_o (req_vec)
    );

    // The two trunk controllers are mirror images; each watches the other.
    for (genvar g = 0; g < NUM_TRUNK; g++) begin : g_trunk
        localparam int PEER = NUM_TRUNK - 1 - g;
        tjx_trunk_ctrl trunk_i (
            .clk_i        (clk_i),
            .rst_i        (rst_i),
            .req_i        (req_vec[g]),
            .car_i        (car_vec[g]),
            .side_lock_i  (side_lock),
            .peer_green_i (green_vec[PEER]),
            .peer_car_i   (car_vec[PEER]),
            .green_o      (green_vec[g]),
            .lock_set_o   (lock_set[g]),
            .lock_rel_o   (lock_rel[g]),
            .served_o     (served_vec[g])
        );
    end

    tjx_side_ctrl side_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .req_i        (req_vec[IDX_EAST]),
        .car_i        (car_vec[IDX_EAST]),
        .trunk_lock_i (top_q.trunk_lock),
        .green_o      (green_vec[IDX_EAST]),
        .lock_o       (side_lock),
        .served_o     (served_vec[IDX_EAST])
    );

    // Shared trunk lock: a claim wins over a release on the same edge.
    always_comb begin
        top_d = top_q;
        if (|lock_set) begin
            top_d.trunk_lock = 1'b1;
        end else if (|lock_rel) begin
            top_d.trunk_lock = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            top_q.trunk_lock <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    assign north_green_o = green_vec[IDX_NORTH];
    assign south_green_o = green_vec[IDX_SOUTH];
    assign east_green_o  = green_vec[IDX_EAST];

    AST_EAST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(east_green_o && (north_green_o || south_green_o)));             // R5
    AST_TRUNK_LOCK_TRACKS_GREENS: assert property (@(posedge clk_i) disable iff (rst_i)
        top_q.trunk_lock == (north_green_o || south_green_o));            // R9
    AST_NORTH_START_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(north_green_o) |-> $past(req_vec[IDX_NORTH]));              // R2
    AST_RESET_DARK: assert property (@(posedge clk_i)
        $past(rst_i) |-> !(north_green_o || south_green_o || east_green_o)); // R1

endmodule

// File: tb/tjx_junction_arbiter_tb_top.sv
module tjx_junction_arbiter_tb_top;

    localparam int SERVICE_BOUND = 80;
    localparam int RAND_CYCLES   = 3000;
    localparam int WATCHDOG_CYC  = 200000;

    logic clk = 1'b0;
    logic rst;
    logic n_car, s_car, e_car;
    logic n_g, s_g, e_g;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    tjx_junction_arbiter dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .north_car_i   (n_car),
        .south_car_i   (s_car),
        .east_car_i    (e_car),
        .north_green_o (n_g),
        .south_green_o (s_g),
        .east_green_o  (e_g)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_bit(input string req, input string what,
                              input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic expect_int(input string req, input string what,
                              input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; n_car = 1'b0; s_car = 1'b0; e_car = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    // R1: greens stay dark during reset even with all cars present.
    task automatic t_reset();
        rst = 1'b1; n_car = 1'b1; s_car = 1'b1; e_car = 1'b1;
        step(4);
        expect_bit("R1", "north in reset", n_g, 1'b0);
        expect_bit("R1", "south in reset", s_g, 1'b0);
        expect_bit("R1", "east in reset",  e_g, 1'b0);
        do_reset();
    endtask

    // R3 latency and R4 hold/drop/clear on north.
    task automatic t_latency_hold();
        do_reset();
        n_car = 1'b1;
        step(2);
        expect_bit("R3", "north before third edge", n_g, 1'b0);
        step(1);
        expect_bit("R3", "north on third edge", n_g, 1'b1);
        step(5);
        expect_bit("R4", "north held while car", n_g, 1'b1);
        n_car = 1'b0;
        step(1);
        expect_bit("R4", "north drops after car low", n_g, 1'b0);
        step(6);
        expect_bit("R4", "north request cleared", n_g, 1'b0);
    endtask

    // R2: one-edge pulse on east is remembered.
    task automatic t_pulse();
        do_reset();
        e_car = 1'b1;
        step(1);
        e_car = 1'b0;
        step(2);
        expect_bit("R2", "east green from pulse", e_g, 1'b1);
        step(1);
        expect_bit("R4", "east off with car low", e_g, 1'b0);
        step(5);
        expect_bit("R4", "east request consumed", e_g, 1'b0);
    endtask

    // R6: trunk overlap.
    task automatic t_overlap();
        do_reset();
        n_car = 1'b1; s_car = 1'b1;
        step(3);
        expect_bit("R6", "north with south", n_g, 1'b1);
        expect_bit("R6", "south with north", s_g, 1'b1);
    endtask

    // R7: east lock blocks new trunk starts; hand-off both ways.
    task automatic t_east_waits();
        do_reset();
        n_car = 1'b1;
        step(3);
        expect_bit("R3", "north up", n_g, 1'b1);
        e_car = 1'b1;
        step(6);
        expect_bit("R5", "east waits behind north", e_g, 1'b0);
        s_car = 1'b1;
        step(5);
        expect_bit("R7", "south blocked by east lock", s_g, 1'b0);
        n_car = 1'b0;
        step(1);
        expect_bit("R4", "north off", n_g, 1'b0);
        expect_bit("R7", "east not yet", e_g, 1'b0);
        step(1);
        expect_bit("R7", "east on after trunk clear", e_g, 1'b1);
        expect_bit("R5", "south still off", s_g, 1'b0);
        e_car = 1'b0;
        step(1);
        expect_bit("R4", "east off", e_g, 1'b0);
        step(1);
        expect_bit("R7", "south after east release", s_g, 1'b1);
    endtask

    // R9: simultaneous trunk end frees the lock.
    task automatic t_simul_end();
        do_reset();
        n_car = 1'b1; s_car = 1'b1;
        step(3);
        n_car = 1'b0; s_car = 1'b0;
        step(1);
        expect_bit("R9", "north off together", n_g, 1'b0);
        expect_bit("R9", "south off together", s_g, 1'b0);
        e_car = 1'b1;
        step(2);
        expect_bit("R9", "east before third edge", e_g, 1'b0);
        step(1);
        expect_bit("R9", "east served, lock free", e_g, 1'b1);
    endtask

    // R10: staggered trunk end keeps the lock until the last one.
    task automatic t_staggered();
        do_reset();
        n_car = 1'b1; s_car = 1'b1;
        step(3);
        e_car = 1'b1;
        step(4);
        n_car = 1'b0;
        step(1);
        expect_bit("R10", "north off first", n_g, 1'b0);
        expect_bit("R10", "south continues", s_g, 1'b1);
        step(3);
        expect_bit("R10", "east held by south", e_g, 1'b0);
        s_car = 1'b0;
        step(1);
        expect_bit("R10", "south off", s_g, 1'b0);
        expect_bit("R10", "east not yet", e_g, 1'b0);
        step(1);
        expect_bit("R10", "east after last trunk", e_g, 1'b1);
    endtask

    // R8: north ready exactly when south is ending.
    task automatic t_peer_ending();
        do_reset();
        s_car = 1'b1;
        step(3);
        expect_bit("R8", "south up", s_g, 1'b1);
        n_car = 1'b1;
        step(2);
        s_car = 1'b0;
        step(1);
        expect_bit("R8", "north held on south end", n_g, 1'b0);
        expect_bit("R8", "south off", s_g, 0);
        step(1);
        expect_bit("R8", "north one edge later", n_g, 1'b1);
        e_car = 1'b1;
        step(5);
        expect_bit("R8", "lock covers late north", e_g, 1'b0);
        n_car = 1'b0;
        step(2);
        expect_bit("R8", "east after north", e_g, 1'b1);
    endtask

    // R5, R11: random traffic.
    task automatic t_random();
        bit   pend[3];
        int   wait_c[3];
        int   served[3];
        logic cars[3];
        logic gv[3];
        int   max_wait = 0;
        int   collide  = 0;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            pend[i] = 1'b0; wait_c[i] = 0; served[i] = 0; cars[i] = 1'b0;
        end
        void'($urandom(32'h5eed));
        for (int c = 0; c < RAND_CYCLES; c++) begin
            step(1);
            gv[0] = n_g; gv[1] = s_g; gv[2] = e_g;
            if (e_g && (n_g || s_g)) collide++;
            for (int i = 0; i < 3; i++) begin
                if (gv[i]) begin
                    if (pend[i]) served[i]++;
                    pend[i] = 1'b0; wait_c[i] = 0;
                end else if (pend[i]) begin
                    wait_c[i]++;
                    if (wait_c[i] > max_wait) max_wait = wait_c[i];
                end
                if (cars[i]) begin
                    if ($urandom % 3 == 0) cars[i] = 1'b0;
                end else if ($urandom % 6 == 0) begin
                    cars[i] = 1'b1;
                end
                if (cars[i] && !gv[i]) pend[i] = 1'b1;
            end
            n_car = cars[0]; s_car = cars[1]; e_car = cars[2];
        end
        expect_int("R5", "random collisions", collide == 0, collide, 0);
        expect_int("R11", "worst wait", max_wait <= SERVICE_BOUND, max_wait, SERVICE_BOUND);
        expect_int("R11", "north served", served[0] > 0, served[0], 1);
        expect_int("R11", "south served", served[1] > 0, served[1], 1);
        expect_int("R11", "east served",  served[2] > 0, served[2], 1);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_latency_hold();
        t_pulse();
        t_overlap();
        t_east_waits();
        t_simul_end();
        t_staggered();
        t_peer_ending();
        t_random();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            report();
        end
    end

endmodule